// File: doc/BRIEF.md
# Shared-Processor Pipeline Stage Scheduler

This controller sequences a three-stage, frame-by-frame audio pipeline. A frequency-domain stage (F) and a time-domain stage (W) run on one shared processing resource. The inverse transform that sits between them runs on a separate hardware engine. The scheduler does not compute anything itself. It issues start pulses and accepts done pulses. It also tracks which frame occupies which stage, so that the two shared-resource stages never overlap and every stage sees frames in order.

The shared resource works through a fixed alternating job list: F of frame n, then W of frame n-1, then F of frame n+1, then W of frame n. The transform for frame n overlaps the F job of frame n+1. When a job's precondition is not met, the scheduler holds the shared resource idle and does not pick a different job. Such a precondition is a new input frame for an F slot, or the transform result for a W slot. When the end of the stream is signalled, no further F jobs start. The pipeline then drains by finishing the outstanding transform and W jobs. Each finished W job produces a one-cycle output-ready strobe that carries the frame tag.

Top module: `stage_sched`

## Requirements
- R1: While reset is asserted, `sp_start`, `xf_start` and `out_ready` are 0. After reset, no job starts while `frame_avail` stays low.
- R2: The shared jobs run in the order F0, F1, W0, F2, W1, F3, W2, and so on. The W slot that follows F0 is skipped because no earlier frame exists. `sp_sel` is 0 for an F job and 1 for a W job. Frame tags count up from 0 modulo 2^TAG_W.
- R3: At most one shared job is in flight. No `sp_start` is issued between an `sp_start` and the `sp_done` that closes it.
- R4: An F job starts only in a cycle after `frame_avail` was sampled high. While the F slot waits for a frame, the shared resource stalls, and no owed W job is moved ahead of the waiting F job.
- R5: The W job for frame n starts only after `xf_done` has been received for frame n.
- R6: The transform for frame n starts only after F of frame n has finished and the engine is idle. Transforms run one at a time, in tag order, once per frame.
- R7: Once `end_of_stream` has been seen, no further F job starts. The pending transforms and W jobs complete, including W of the last frame. The stream ends with exactly 2N shared jobs for N frames.
- R8: `out_ready` is high for exactly one cycle, in the cycle after the `sp_done` that ends a W job. In that cycle `out_tag` equals the tag of that W job.
- R9: An `sp_done` or `xf_done` that arrives while no matching job is in flight is ignored. It produces no job, no strobe and no shift in the later job order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_avail | input | 1 | A new input frame is ready for an F job; the F start takes it |
| end_of_stream | input | 1 | No more frames will come; the scheduler drains (held internally once seen) |
| sp_start | output | 1 | One-cycle start pulse to the shared resource |
| sp_sel | output | 1 | Job kind of the shared start: 0 = F, 1 = W |
| sp_tag | output | TAG_W | Frame tag of the shared job |
| sp_done | input | 1 | One-cycle completion pulse from the shared resource |
| xf_start | output | 1 | One-cycle start pulse to the transform engine |
| xf_tag | output | TAG_W | Frame tag of the transform job |
| xf_done | input | 1 | One-cycle completion pulse from the transform engine |
| out_ready | output | 1 | One-cycle strobe: a frame has left the W stage |
| out_tag | output | TAG_W | Tag of the frame flagged by `out_ready` |

## Verification
Suppose the slot register or the F/W counters get a wrong value. The next `sp_start` then shows the wrong `sp_sel` or `sp_tag`, one cycle after the shared resource was freed. A wrong owed-W count after reset shows up at once as an early W for a frame that never existed, or as a missing W0. A broken handshake between the transform tracker and the sequencer shows at a W start, which comes before that frame's `xf_done` or stays stuck after it. A lost end-of-stream state shows up as a trailing W that never arrives, or as an F issued after the stream ended.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    JOB_F = 1'b0,
    JOB_W = 1'b1
  } job_e;

  // Distance a - b between two wrapping tag counters of width w.
  function automatic int unsigned tag_gap(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input int unsigned w);
    logic [15:0] mask;
    logic [15:0] diff;
    mask = (16'd1 << w) - 16'd1;
    diff = (a - b) & mask;
    return int'(diff);
  endfunction

  function automatic job_e other_job(input job_e j);
    return (j == JOB_F) ? JOB_W : JOB_F;
  endfunction

endpackage

// File: rtl/xform_track.sv
module xform_track
  import sched_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_fin,
  input  logic             xf_done,
  output logic             xf_start,
  output logic [TAG_W-1:0] xf_tag,
  output logic [TAG_W-1:0] x_done_cnt
);
  localparam logic [TAG_W-1:0] ONE = 1;

  logic [TAG_W-1:0] f_fin_cnt;
  logic [TAG_W-1:0] x_start_cnt;
  logic             busy;

  wire go_x   = !busy && (f_fin_cnt != x_start_cnt);
  wire x_end  = busy && xf_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_fin_cnt   <= '0;
      x_start_cnt <= '0;
      x_done_cnt  <= '0;
      busy        <= 1'b0;
      xf_start    <= 1'b0;
      xf_tag      <= '0;
    end else begin
      xf_start <= 1'b0;
      if (f_fin) f_fin_cnt <= f_fin_cnt + ONE;
      if (go_x) begin
        busy        <= 1'b1;
        xf_start    <= 1'b1;
        xf_tag      <= x_start_cnt;
        x_start_cnt <= x_start_cnt + ONE;
      end
      if (x_end) begin
        busy       <= 1'b0;
        x_done_cnt <= x_done_cnt + ONE;
      end
    end
  end

  // R6
  xf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_gap(16'(x_start_cnt), 16'(x_done_cnt), TAG_W) <= 1);

  // R6
  xf_after_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xf_start |-> tag_gap(16'(f_fin_cnt), 16'(xf_tag), TAG_W) != 0);

  // R6
  xf_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_end |=> !xf_start);

endmodule

// File: rtl/shared_slot_seq.sv
module shared_slot_seq
  import sched_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_avail,
  input  logic             eos,
  input  logic             sp_done,
  input  logic [TAG_W-1:0] x_done_cnt,
  output logic             sp_start,
  output logic             sp_sel,
  output logic [TAG_W-1:0] sp_tag,
  output logic             f_fin,
  output logic             out_ready,
  output logic [TAG_W-1:0] out_tag
);
  localparam logic [TAG_W-1:0] ONE = 1;

  job_e             slot;
  logic             busy;
  logic             eos_q;
  logic [TAG_W-1:0] f_cnt;
  logic [TAG_W-1:0] w_cnt;
  logic [TAG_W-1:0] job_tag;

  // Named internal events
  wire [31:0] pend    = tag_gap(16'(f_cnt), 16'(w_cnt), TAG_W);
  wire        w_owed  = eos_q ? (pend != 0) : (pend >= 2);
  wire        x_ready = (x_done_cnt != w_cnt);
  wire        go_f    = !busy && (slot == JOB_F) && frame_avail && !eos_q;
  wire        go_w    = !busy && (slot == JOB_W) && w_owed && x_ready;
  wire        skip    = !busy && (((slot == JOB_W) && !w_owed) ||
                                  ((slot == JOB_F) && eos_q && (pend != 0)));
  wire        job_end = busy && sp_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= JOB_F;
      busy      <= 1'b0;
      eos_q     <= 1'b0;
      f_cnt     <= '0;
      w_cnt     <= '0;
      job_tag   <= '0;
      sp_start  <= 1'b0;
      sp_sel    <= 1'b0;
      sp_tag    <= '0;
      f_fin     <= 1'b0;
      out_ready <= 1'b0;
      out_tag   <= '0;
    end else begin
      sp_start  <= 1'b0;
      f_fin     <= 1'b0;
      out_ready <= 1'b0;
      if (eos) eos_q <= 1'b1;
      if (go_f) begin
        busy     <= 1'b1;
        sp_start <= 1'b1;
        sp_sel   <= JOB_F;
        sp_tag   <= f_cnt;
        job_tag  <= f_cnt;
        f_cnt    <= f_cnt + ONE;
      end else if (go_w) begin
        busy     <= 1'b1;
        sp_start <= 1'b1;
        sp_sel   <= JOB_W;
        sp_tag   <= w_cnt;
        job_tag  <= w_cnt;
        w_cnt    <= w_cnt + ONE;
      end else if (skip) begin
        slot <= other_job(slot);
      end
      if (job_end) begin
        busy <= 1'b0;
        slot <= other_job(slot);
        if (slot == JOB_F) begin
          f_fin <= 1'b1;
        end else begin
          out_ready <= 1'b1;
          out_tag   <= job_tag;
        end
      end
    end
  end

  // R3
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sp_done) |=> !sp_start);

  // R4
  f_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_start && (sp_sel == JOB_F)) |-> $past(frame_avail));

  // R5
  w_after_xf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_start && (sp_sel == JOB_W)) |-> tag_gap(16'(x_done_cnt), 16'(sp_tag), TAG_W) != 0);

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |=> !out_ready);

endmodule

// File: rtl/stage_sched.sv
module stage_sched
  import sched_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_avail,
  input  logic             end_of_stream,
  output logic             sp_start,
  output logic             sp_sel,
  output logic [TAG_W-1:0] sp_tag,
  input  logic             sp_done,
  output logic             xf_start,
  output logic [TAG_W-1:0] xf_tag,
  input  logic             xf_done,
  output logic             out_ready,
  output logic [TAG_W-1:0] out_tag
);
  logic             f_fin;
  logic [TAG_W-1:0] x_done_cnt;

  shared_slot_seq #(.TAG_W(TAG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_avail(frame_avail),
    .eos        (end_of_stream),
    .sp_done    (sp_done),
    .x_done_cnt (x_done_cnt),
    .sp_start   (sp_start),
    .sp_sel     (sp_sel),
    .sp_tag     (sp_tag),
    .f_fin      (f_fin),
    .out_ready  (out_ready),
    .out_tag    (out_tag)
  );

  xform_track #(.TAG_W(TAG_W)) u_xf (
    .clk       (clk),
    .rst_n     (rst_n),
    .f_fin     (f_fin),
    .xf_done   (xf_done),
    .xf_start  (xf_start),
    .xf_tag    (xf_tag),
    .x_done_cnt(x_done_cnt)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sp_start && !xf_start && !out_ready) || rst_n);

endmodule

// File: tb/stage_sched_test.sv
module stage_sched_test;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_avail = 1'b0;
  logic end_of_stream = 1'b0;
  logic sp_done = 1'b0;
  logic xf_done = 1'b0;
  logic sp_start, sp_sel, xf_start, out_ready;
  logic [TAG_W-1:0] sp_tag, xf_tag, out_tag;

  always #4 clk = ~clk;

  stage_sched #(.TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .frame_avail(frame_avail),
    .end_of_stream(end_of_stream), .sp_start(sp_start), .sp_sel(sp_sel),
    .sp_tag(sp_tag), .sp_done(sp_done), .xf_start(xf_start),
    .xf_tag(xf_tag), .xf_done(xf_done), .out_ready(out_ready),
    .out_tag(out_tag)
  );

  int checks = 0;
  int errors = 0;

  // bench model state
  bit mon_en = 0;
  int n_frames, f_issued, jobs_seen, outs_seen, xf_seen;
  int f_lat, w_lat, x_lat, sp_cd, x_cd;
  bit bbusy, xbusy, exp_out, last_avail, spur_req;
  int cur_sel, cur_tag, cur_xtag, exp_out_tag;
  int pause_at, pause_len, pause_cnt;
  bit fdone [16];
  bit xdone [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected k-th shared job for an n-frame stream: F0, F1, W0, F2, W1, ..., W(n-1)
  task automatic exp_job(input int k, input int n, output int sel, output int tag);
    if (k == 0) begin sel = 0; tag = 0; end
    else if (k == 2*n-1) begin sel = 1; tag = (n-1) % 16; end
    else if (k % 2 == 1) begin sel = 0; tag = ((k+1)/2) % 16; end
    else begin sel = 1; tag = (k/2 - 1) % 16; end
  endtask

  // Monitor, engine models and frame source in one process
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        last_avail = frame_avail;
        if (out_ready || exp_out)
          chk(out_ready == exp_out && (!exp_out || out_tag == exp_out_tag[TAG_W-1:0]),
              "R8", "out strobe/tag", {out_ready, 4'(out_tag)}, {exp_out, 4'(exp_out_tag)});
        if (out_ready) outs_seen++;
        exp_out = 0;
        if (sp_start) begin
          int es, et;
          chk(!bbusy, "R3", "start while job in flight", 1, 0);
          if (jobs_seen >= 2*n_frames)
            chk(0, "R7", "extra shared job", jobs_seen, 2*n_frames);
          else begin
            exp_job(jobs_seen, n_frames, es, et);
            chk(sp_sel == es[0] && sp_tag == et[TAG_W-1:0], "R2", "job sel*16+tag",
                sp_sel*16 + sp_tag, es*16 + et);
          end
          if (!sp_sel) begin
            chk(last_avail, "R4", "F start without frame", 0, 1);
            f_issued++;
          end else
            chk(xdone[sp_tag], "R5", "W before transform done, tag", sp_tag, sp_tag);
          jobs_seen++;
          bbusy = 1; cur_sel = sp_sel; cur_tag = sp_tag;
          sp_cd = sp_sel ? w_lat + 1 : f_lat + 1;
        end
        if (xf_start) begin
          chk(!xbusy && fdone[xf_tag] && xf_tag == 4'(xf_seen % 16), "R6",
              "transform start tag", xf_tag, xf_seen % 16);
          xbusy = 1; x_cd = x_lat + 1; cur_xtag = xf_tag; xf_seen++;
        end
        sp_done = 0;
        xf_done = 0;
        if (bbusy) begin
          sp_cd--;
          if (sp_cd == 0) begin
            sp_done = 1; bbusy = 0;
            if (cur_sel == 0) fdone[cur_tag] = 1;
            else begin exp_out = 1; exp_out_tag = cur_tag; end
          end
        end
        if (xbusy) begin
          x_cd--;
          if (x_cd == 0) begin xf_done = 1; xbusy = 0; xdone[cur_xtag] = 1; end
        end
        if (spur_req) begin sp_done = 1; xf_done = 1; spur_req = 0; end
        if (f_issued == pause_at && pause_cnt < pause_len) begin
          pause_cnt++;
          frame_avail = 0;
        end else
          frame_avail = (f_issued < n_frames);
        end_of_stream = (n_frames > 0) && (f_issued >= n_frames);
      end
    end
  end

  task automatic do_reset(input int fl, input int wl, input int xl);
    mon_en = 0;
    @(negedge clk);
    rst_n = 0; frame_avail = 0; end_of_stream = 0; sp_done = 0; xf_done = 0;
    n_frames = 0; f_issued = 0; jobs_seen = 0; outs_seen = 0; xf_seen = 0;
    f_lat = fl; w_lat = wl; x_lat = xl; sp_cd = 0; x_cd = 0;
    bbusy = 0; xbusy = 0; exp_out = 0; spur_req = 0;
    pause_at = -1; pause_len = 0; pause_cnt = 0;
    for (int i = 0; i < 16; i++) begin fdone[i] = 0; xdone[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!sp_start && !xf_start && !out_ready, "R1", "strobes in reset",
        {sp_start, xf_start, out_ready}, 0);
    rst_n = 1;
    mon_en = 1;
  endtask

  task automatic wait_done(input int n, input string tagname);
    int guard = 0;
    while (outs_seen < n && guard < 6000) begin @(negedge clk); guard++; end
    repeat (30) @(negedge clk);
    chk(outs_seen == n, "R7", {tagname, " outputs"}, outs_seen, n);
    chk(jobs_seen == 2*n, "R7", {tagname, " shared jobs"}, jobs_seen, 2*n);
    chk(xf_seen == n, "R6", {tagname, " transforms"}, xf_seen, n);
  endtask

  task automatic t_reset_idle;
    do_reset(2, 2, 2);
    repeat (12) @(negedge clk);
    chk(jobs_seen == 0 && xf_seen == 0, "R1", "jobs with no frame", jobs_seen, 0);
  endtask

  task automatic t_basic;
    do_reset(3, 2, 2);
    n_frames = 6;
    wait_done(6, "basic");
  endtask

  task automatic t_slow_xform;
    do_reset(2, 1, 25);
    n_frames = 5;
    wait_done(5, "slow transform R5");
  endtask

  task automatic t_starve;
    do_reset(2, 2, 3);
    pause_at = 3; pause_len = 40;
    n_frames = 6;
    wait_done(6, "starve R4");
    chk(pause_cnt == 40, "R4", "pause cycles applied", pause_cnt, 40);
  endtask

  task automatic t_single;
    do_reset(4, 3, 5);
    n_frames = 1;
    wait_done(1, "single frame R2");
  endtask

  task automatic t_spurious;
    do_reset(2, 2, 2);
    repeat (2) @(negedge clk);
    spur_req = 1;
    repeat (8) @(negedge clk);
    chk(jobs_seen == 0 && xf_seen == 0 && outs_seen == 0, "R9", "activity after stray done",
        jobs_seen + xf_seen + outs_seen, 0);
    n_frames = 3;
    wait_done(3, "after stray done R9");
  endtask

  task automatic t_long;
    do_reset(1, 1, 7);
    n_frames = 12;
    wait_done(12, "long");
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_idle();
    t_basic();
    t_slow_xform();
    t_starve();
    t_single();
    t_spurious();
    t_long();
    finish_run();
  end

endmodule